// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a segment selector plus a 32-bit offset into a linear address by reading the segment's descriptor from an in-memory table. It holds two table base registers, one for a system-wide table and one for a per-task table. A selector bit picks which table is used, and the selector's upper bits index into that table. The block computes where the 8-byte descriptor lives and reads it as two 32-bit words through a synchronous read port. It then checks the descriptor and returns either the segment base plus the offset, or a fault code.

A requester presents a selector, an offset, a read/write flag and its current privilege level with a one-cycle `req_valid` pulse while `busy` is low. The translation runs through five states: idle, low-word fetch, high-word fetch, check and done. `done` pulses for one cycle with the result, and the block then returns to idle. Requests that arrive while `busy` is high are dropped. The table base registers are loaded through a small write port.

Top module: `seg_xlate`

## Requirements
- R1: After reset `busy`, `done` and `mem_rd_en` are 0, `fault` is 0 and `lin_addr` is 0, and both table base registers hold 0.
- R2: Selector bit 2 chooses the table (0 = global base register, 1 = local base register). Selector bits [15:3] are the index and bits [1:0] are ignored. The descriptor address is the chosen base plus index×8. The low word is read at that address in the first cycle after acceptance, and the high word at address+4 in the next cycle.
- R3: Descriptor layout. The low word is the segment base. In the high word, bits [23:0] are the limit, bit 24 is present, bit 25 is read-only, bits [27:26] are the descriptor privilege level, and bits [31:28] are ignored.
- R4: With no fault, `lin_addr` equals base + offset modulo 2^32 and `fault` is 0.
- R5: A clear present bit gives fault code 1. This takes priority over every other check.
- R6: A request privilege numerically less than the descriptor privilege gives fault code 2. This takes priority over limit and write checks.
- R7: An offset greater than the limit gives fault code 3. An offset equal to the limit is allowed. This takes priority over the write check.
- R8: A write to a read-only segment gives fault code 4. A read of the same segment succeeds.
- R9: `done` is high for exactly one cycle, in the fourth cycle after the accepting clock edge. `busy` is high from the cycle after acceptance through the `done` cycle, then low.
- R10: A `req_valid` seen while `busy` is high is ignored. It changes neither the result in progress nor starts another translation.
- R11: While `busy` is low, `tbl_wr_en` loads `tbl_wr_data` into the global base register (`tbl_wr_sel`=0) or the local base register (`tbl_wr_sel`=1). A changed base moves the descriptor address of later requests.
- R12: When `fault` is nonzero, `lin_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Load a table base register |
| tbl_wr_sel | input | 1 | 0 = global base, 1 = local base |
| tbl_wr_data | input | 32 | New base value |
| req_valid | input | 1 | Start a translation (taken when not busy) |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| req_write | input | 1 | 1 = write access |
| req_priv | input | 2 | Requester's effective privilege level |
| busy | output | 1 | Translation in progress |
| done | output | 1 | One-cycle result strobe |
| lin_addr | output | 32 | Linear address (0 on fault) |
| fault | output | 3 | 0 none, 1 not present, 2 privilege, 3 limit, 4 write to read-only |
| mem_rd_en | output | 1 | Descriptor memory read strobe |
| mem_addr | output | 32 | Descriptor memory byte address |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd_en` |

## Verification
The vectors pair global and local selectors that share an index, so a wrong table pick shows up as a different descriptor address and result. Ignored low selector bits are also included. Each fault is hit on its own. Further vectors combine two failing conditions at once, so the fault priority order is pinned down. The limit is probed exactly at and one past its value, and one base plus offset wraps past 2^32 to expose a truncated adder. Directed runs reprogram a base register, and inject a second request mid-translation to show it is dropped.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   localparam int DESC_WORD_W = 32;
   localparam int PRES_POS    = 24;
   localparam int RO_POS      = 25;
   localparam int DPL_POS     = 26;
   localparam int MAX_LIM_W   = 24;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_FETCH_LO = 3'd1,
      ST_FETCH_HI = 3'd2,
      ST_CHECK    = 3'd3,
      ST_DONE     = 3'd4
   } xl_state_e;

   typedef enum logic [2:0] {
      FLT_NONE     = 3'd0,
      FLT_ABSENT   = 3'd1,
      FLT_PRIV     = 3'd2,
      FLT_LIMIT    = 3'd3,
      FLT_WRITE_RO = 3'd4
   } xl_fault_e;

endpackage

// File: rtl/seg_base_regs.sv
module seg_base_regs #(
   parameter int ADDR_W = 32,
   parameter int N_TBL  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              rd_sel,
   output logic [ADDR_W-1:0] rd_base
);

   if (N_TBL != 2) begin : g_bad_ntbl
      $error("seg_base_regs: N_TBL must be 2");
   end

   logic [ADDR_W-1:0] base_q [N_TBL];

   for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
      always_ff @(posedge clk) begin
         if (!rst_n)
            base_q[t] <= '0;
         else if (wr_en && (wr_sel == 1'(t)))
            base_q[t] <= wr_data;
      end

      // R11: a base register changes only when written
      p_base_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && (wr_sel == 1'(t))) |=> $stable(base_q[t]));
   end

   assign rd_base = base_q[rd_sel];

endmodule

// File: rtl/seg_desc_addr.sv
module seg_desc_addr #(
   parameter int ADDR_W = 32,
   parameter int SEL_W  = 16,
   parameter int TI_POS = 2
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [ADDR_W-1:0] base,
   output logic              ti,
   output logic [ADDR_W-1:0] desc_addr
);

   localparam int IDX_W    = SEL_W - TI_POS - 1;
   localparam int SCALED_W = IDX_W + 3;

   if (IDX_W < 1 || SCALED_W > ADDR_W) begin : g_bad_sel
      $error("seg_desc_addr: selector index does not fit the address");
   end

   logic [IDX_W-1:0]    idx;
   logic [SCALED_W-1:0] scaled;
   logic                unused_rpl;

   assign ti         = sel[TI_POS];
   assign idx        = sel[SEL_W-1:TI_POS+1];
   assign scaled     = {idx, 3'b000};
   assign desc_addr  = base + ADDR_W'(scaled);
   assign unused_rpl = ^sel[TI_POS-1:0];

endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LIMIT_W = 24,
   parameter int PRIV_W  = 2
) (
   input  logic [DESC_WORD_W-1:0] desc_lo,
   input  logic [DESC_WORD_W-1:0] desc_hi,
   input  logic [ADDR_W-1:0]      off,
   input  logic                   is_write,
   input  logic [PRIV_W-1:0]      priv,
   output xl_fault_e              fault,
   output logic [ADDR_W-1:0]      lin
);

   if (LIMIT_W < 1 || LIMIT_W > MAX_LIM_W) begin : g_bad_lim
      $error("seg_desc_check: LIMIT_W out of range");
   end
   if (DPL_POS + PRIV_W > DESC_WORD_W) begin : g_bad_priv
      $error("seg_desc_check: PRIV_W too wide for descriptor");
   end

   logic [LIMIT_W-1:0] lim;
   logic [ADDR_W-1:0]  lim_ext;
   logic [PRIV_W-1:0]  dpl;
   logic               present;
   logic               read_only;
   logic [ADDR_W-1:0]  seg_base;
   logic               unused_hi;

   assign lim       = desc_hi[LIMIT_W-1:0];
   assign present   = desc_hi[PRES_POS];
   assign read_only = desc_hi[RO_POS];
   assign dpl       = desc_hi[DPL_POS +: PRIV_W];
   assign seg_base  = desc_lo[ADDR_W-1:0];
   assign unused_hi = ^{desc_hi[DESC_WORD_W-1:DPL_POS+PRIV_W], desc_hi[PRES_POS-1:LIMIT_W]};

   if (LIMIT_W < ADDR_W) begin : g_lim_zext
      assign lim_ext = {{(ADDR_W-LIMIT_W){1'b0}}, lim};
   end else begin : g_lim_trunc
      assign lim_ext = lim[ADDR_W-1:0];
   end

   if (ADDR_W < DESC_WORD_W) begin : g_lo_spare
      logic unused_lo;
      assign unused_lo = ^desc_lo[DESC_WORD_W-1:ADDR_W];
   end

   always_comb begin
      fault = FLT_NONE;
      if (!present)
         fault = FLT_ABSENT;
      else if (priv < dpl)
         fault = FLT_PRIV;
      else if (off > lim_ext)
         fault = FLT_LIMIT;
      else if (is_write && read_only)
         fault = FLT_WRITE_RO;
   end

   assign lin = (fault == FLT_NONE) ? (seg_base + off) : '0;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int SEL_W   = 16,
   parameter int TI_POS  = 2,
   parameter int LIMIT_W = 24,
   parameter int PRIV_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_wr_en,
   input  logic              tbl_wr_sel,
   input  logic [31:0]       tbl_wr_data,
   input  logic              req_valid,
   input  logic [15:0]       req_sel,
   input  logic [31:0]       req_off,
   input  logic              req_write,
   input  logic [1:0]        req_priv,
   output logic              busy,
   output logic              done,
   output logic [31:0]       lin_addr,
   output logic [2:0]        fault,
   output logic              mem_rd_en,
   output logic [31:0]       mem_addr,
   input  logic [31:0]       mem_rdata
);

   if (ADDR_W != 32 || SEL_W != 16 || PRIV_W != 2) begin : g_bad_port
      $error("seg_xlate: port widths are fixed at 32/16/2");
   end

   localparam logic [ADDR_W-1:0] HI_STEP = ADDR_W'(DESC_WORD_W / 8);

   xl_state_e         state_q, state_d;
   logic [ADDR_W-1:0] desc_addr_q;
   logic [ADDR_W-1:0] off_q;
   logic              wr_q;
   logic [PRIV_W-1:0] priv_q;
   logic [31:0]       lo_q;
   logic [ADDR_W-1:0] res_addr_q;
   xl_fault_e         res_fault_q;

   logic              ti;
   logic [ADDR_W-1:0] tbl_base;
   logic [ADDR_W-1:0] desc_addr_c;
   xl_fault_e         chk_fault;
   logic [ADDR_W-1:0] chk_lin;
   logic              accept;

   seg_base_regs #(.ADDR_W(ADDR_W), .N_TBL(2)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr_en),
      .wr_sel  (tbl_wr_sel),
      .wr_data (tbl_wr_data),
      .rd_sel  (ti),
      .rd_base (tbl_base)
   );

   seg_desc_addr #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .TI_POS(TI_POS)) u_daddr (
      .sel       (req_sel),
      .base      (tbl_base),
      .ti        (ti),
      .desc_addr (desc_addr_c)
   );

   seg_desc_check #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .PRIV_W(PRIV_W)) u_chk (
      .desc_lo  (lo_q),
      .desc_hi  (mem_rdata),
      .off      (off_q),
      .is_write (wr_q),
      .priv     (priv_q),
      .fault    (chk_fault),
      .lin      (chk_lin)
   );

   assign accept = (state_q == ST_IDLE) && req_valid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:     if (req_valid) state_d = ST_FETCH_LO;
         ST_FETCH_LO: state_d = ST_FETCH_HI;
         ST_FETCH_HI: state_d = ST_CHECK;
         ST_CHECK:    state_d = ST_DONE;
         ST_DONE:     state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         desc_addr_q <= '0;
         off_q       <= '0;
         wr_q        <= 1'b0;
         priv_q      <= '0;
         lo_q        <= '0;
         res_addr_q  <= '0;
         res_fault_q <= FLT_NONE;
      end else begin
         state_q <= state_d;
         if (accept) begin
            desc_addr_q <= desc_addr_c;
            off_q       <= req_off;
            wr_q        <= req_write;
            priv_q      <= req_priv;
         end
         if (state_q == ST_FETCH_HI)
            lo_q <= mem_rdata;
         if (state_q == ST_CHECK) begin
            res_addr_q  <= chk_lin;
            res_fault_q <= chk_fault;
         end
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign mem_rd_en = (state_q == ST_FETCH_LO) || (state_q == ST_FETCH_HI);
   assign mem_addr  = (state_q == ST_FETCH_HI) ? (desc_addr_q + HI_STEP) : desc_addr_q;
   assign lin_addr  = res_addr_q;
   assign fault     = res_fault_q;

   // R2: the high word is read right after the low word, four bytes on
   p_hi_follows_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FETCH_LO) |=> (mem_rd_en && (mem_addr == $past(mem_addr) + HI_STEP)));

   // R2: memory is only read during a translation
   p_rd_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> busy);

   // R9: done lasts one cycle and the block then goes idle
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R9: done only comes after both fetches
   p_done_after_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !$past(mem_rd_en));

   // R10: busy only starts from an accepted request
   p_start_on_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   // R12: faulting results carry no address
   p_fault_no_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (fault != 3'd0)) |-> (lin_addr == 32'd0));

endmodule

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tbl_wr_en, tbl_wr_sel;
   logic [31:0] tbl_wr_data;
   logic        req_valid;
   logic [15:0] req_sel;
   logic [31:0] req_off;
   logic        req_write;
   logic [1:0]  req_priv;
   logic        busy, done, mem_rd_en;
   logic [31:0] lin_addr, mem_addr;
   logic [2:0]  fault;
   logic [31:0] mem_rdata;

   logic [31:0] mem [256];
   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] gbase, lbase;

   always #2 clk = ~clk;

   seg_xlate dut (
      .clk(clk), .rst_n(rst_n),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_sel(tbl_wr_sel), .tbl_wr_data(tbl_wr_data),
      .req_valid(req_valid), .req_sel(req_sel), .req_off(req_off),
      .req_write(req_write), .req_priv(req_priv),
      .busy(busy), .done(done), .lin_addr(lin_addr), .fault(fault),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
   );

   always_ff @(posedge clk)
      if (mem_rd_en) mem_rdata <= mem[mem_addr[9:2]];

   typedef struct packed {
      logic [15:0] sel;
      logic [31:0] off;
      logic        wr;
      logic [1:0]  pr;
      logic [31:0] exp_lin;
      logic [2:0]  exp_flt;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{16'h0008, 32'h0000_1234, 1'b0, 2'd0, 32'h0010_1234, 3'd0}, // R4 global idx1
      '{16'h0008, 32'h0000_FFFF, 1'b0, 2'd0, 32'h0010_FFFF, 3'd0}, // R7 offset == limit
      '{16'h0008, 32'h0001_0000, 1'b0, 2'd0, 32'h0000_0000, 3'd3}, // R7 one past limit
      '{16'h0010, 32'h0000_0010, 1'b1, 2'd0, 32'h0000_0000, 3'd4}, // R8 write read-only
      '{16'h0010, 32'h0000_0010, 1'b0, 2'd0, 32'h1234_0010, 3'd0}, // R8 read read-only
      '{16'h0018, 32'hFFFF_0000, 1'b1, 2'd0, 32'h0000_0000, 3'd1}, // R5 absent beats all
      '{16'h0020, 32'h0000_2000, 1'b0, 2'd1, 32'h0000_0000, 3'd2}, // R6 priv 1 < dpl 2
      '{16'h0020, 32'h0000_2000, 1'b0, 2'd2, 32'h0000_1000, 3'd0}, // R4 wraps 2^32
      '{16'h000C, 32'h0000_0080, 1'b0, 2'd1, 32'h0A00_0080, 3'd0}, // R2 local idx1
      '{16'h000F, 32'h0000_0080, 1'b0, 2'd1, 32'h0A00_0080, 3'd0}, // R2 low bits ignored
      '{16'h002C, 32'h0000_0010, 1'b1, 2'd3, 32'h0000_0000, 3'd4}, // R8 local read-only
      '{16'h002C, 32'h0000_0000, 1'b1, 2'd2, 32'h0000_0000, 3'd2}, // R6 beats R8
      '{16'h002C, 32'h0000_0011, 1'b1, 2'd3, 32'h0000_0000, 3'd3}  // R7 beats R8, R3 fields
   };

   function automatic logic [31:0] mk_hi(logic [1:0] dpl, logic ro, logic p, logic [23:0] lim);
      return {4'hF, dpl, ro, p, lim}; // R3: top nibble must be ignored
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   task automatic wr_base(input logic s, input logic [31:0] d);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_sel = s; tbl_wr_data = d;
      @(negedge clk);
      tbl_wr_en = 1'b0;
      if (s) lbase = d; else gbase = d;
   endtask

   // Runs one translation; optionally injects a second request while busy (R10)
   task automatic run_one(input vec_t v, input string tag, input bit inject);
      logic [31:0] dexp;
      dexp = (v.sel[2] ? lbase : gbase) + {16'h0, v.sel[15:3], 3'b000};
      @(negedge clk);
      req_sel = v.sel; req_off = v.off; req_write = v.wr; req_priv = v.pr;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " R9 busy"}, {31'h0, busy}, 32'd1);
      chk({tag, " R2 lo rd_en"}, {31'h0, mem_rd_en}, 32'd1);
      chk({tag, " R2 lo addr"}, mem_addr, dexp);
      if (inject) begin
         req_sel = 16'h0008; req_off = 32'h0; req_write = 1'b0; req_priv = 2'd3;
         req_valid = 1'b1;
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " R2 hi addr"}, mem_addr, dexp + 32'd4);
      @(negedge clk);
      chk({tag, " R9 no early done"}, {31'h0, done}, 32'd0);
      @(negedge clk);
      chk({tag, " R9 done"}, {31'h0, done}, 32'd1);
      chk({tag, " lin"}, lin_addr, v.exp_lin);
      chk({tag, " fault"}, {29'h0, fault}, {29'h0, v.exp_flt});
      @(negedge clk);
      chk({tag, " R9 done drops"}, {31'h0, done}, 32'd0);
      chk({tag, " R9 idle"}, {31'h0, busy}, 32'd0);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      // global table at 0x000
      mem[2]  = 32'h0010_0000; mem[3]  = mk_hi(2'd0, 1'b0, 1'b1, 24'h00FFFF);
      mem[4]  = 32'h1234_0000; mem[5]  = mk_hi(2'd0, 1'b1, 1'b1, 24'h000FFF);
      mem[6]  = 32'h5555_0000; mem[7]  = mk_hi(2'd3, 1'b1, 1'b0, 24'h000000);
      mem[8]  = 32'hFFFF_F000; mem[9]  = mk_hi(2'd2, 1'b0, 1'b1, 24'hFFFFFF);
      // local table at 0x200
      mem[130] = 32'h0A00_0000; mem[131] = mk_hi(2'd1, 1'b0, 1'b1, 24'h0000FF);
      mem[138] = 32'h0000_0100; mem[139] = mk_hi(2'd3, 1'b1, 1'b1, 24'h000010);
      // alternate local table at 0x100
      mem[66] = 32'h0B00_0000; mem[67] = mk_hi(2'd0, 1'b0, 1'b1, 24'h0000FF);

      gbase = 32'h0; lbase = 32'h0;
      rst_n = 1'b0; tbl_wr_en = 1'b0; tbl_wr_sel = 1'b0; tbl_wr_data = 32'h0;
      req_valid = 1'b0; req_sel = 16'h0; req_off = 32'h0; req_write = 1'b0; req_priv = 2'd0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy", {31'h0, busy}, 32'd0);
      chk("R1 done", {31'h0, done}, 32'd0);
      chk("R1 rd_en", {31'h0, mem_rd_en}, 32'd0);
      chk("R1 fault", {29'h0, fault}, 32'd0);
      chk("R1 lin", lin_addr, 32'd0);
      rst_n = 1'b1;

      // R1: base registers reset to zero, so global idx1 is read at 0x008
      run_one(VECS[0], "R1 base zero", 1'b0);

      // R11: program bases through the write port
      wr_base(1'b0, 32'h0000_0000);
      wr_base(1'b1, 32'h0000_0200);

      for (int i = 0; i < NV; i++) begin
         string t;
         t = $sformatf("vec%0d (R3 R4 R5 R6 R7 R8 R12)", i);
         run_one(VECS[i], t, 1'b0);
      end

      // R10: a request while busy is dropped
      run_one(VECS[8], "R10 inject", 1'b1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R10 no second run", {30'h0, busy, done}, 32'd0);
      end

      // R11: moving the local base moves the descriptor
      wr_base(1'b1, 32'h0000_0100);
      run_one('{16'h000C, 32'h0000_0080, 1'b0, 2'd1, 32'h0B00_0080, 3'd0}, "R11 new lbase", 1'b0);

      finish_run();
   end

endmodule